// File: doc/BRIEF.md
# Byte ALU with Selective Status Flags

This block is the arithmetic-logic stage of a small 8-bit RISC core. It adds, subtracts, ANDs, ORs and XORs two bytes, or a byte and an immediate, with or without the incoming carry. It also forms the one's complement or two's complement of a single byte. It can add an immediate to, or subtract an immediate from, a 16-bit register pair.

Each operation has its own set of status flags that it may change. The block returns the new flag vector together with a write-enable mask. Flags outside the mask come back with the value they had on input. Byte operations deliver their result one cycle after they are accepted. Word operations hold a busy indication for one cycle and deliver both result bytes on the following cycle.

The surrounding core supplies the opcode, the operands, the high byte of the pair and the current status vector. It writes back the result and the masked flags when `done` pulses.

Top module: `alu8_flags`

## Requirements
- R1: With opcode 0x0 (add) or 0x1 (add with carry), the result is rd + b (+ C for 0x1). Here b is `imm` when `use_imm` is 1 and `rr` otherwise. Flag vectors use bit 0 = Z, 1 = C, 2 = N, 3 = V, 4 = H, 5 = S. The write mask is 0x1F. C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, N is bit 7 and Z marks a zero result.
- R2: With opcode 0x2 (subtract) or 0x3 (subtract with borrow), the result is rd − b (− C for 0x3), with b selected as in R1. The mask is 0x1F. C is the borrow out of bit 7, H is the borrow out of bit 3, and V is signed overflow.
- R3: For opcode 0x3, Z is 1 only when the result is zero and the incoming Z is 1. A nonzero result clears Z; a zero result keeps the incoming Z.
- R4: Opcodes 0x4, 0x5 and 0x6 give the bitwise AND, OR and XOR of rd and b. They write only Z, N and V (mask 0x0D), and V is 0.
- R5: Opcode 0x7 gives ~rd with mask 0x0F. C is 1 and V is 0.
- R6: Opcode 0x8 gives 0 − rd with mask 0x1F. C and H are the borrows of that subtraction, and V is 1 only for rd = 0x80.
- R7: A byte operation accepted on a clock edge raises `done` on the next edge, with `busy` low.
- R8: Opcodes 0x9 and 0xA add or subtract `imm` to or from the pair {rd_hi, rd}. `busy` is high for the first cycle after acceptance and `done` rises one edge later. The result appears as {res_hi, res}.
- R9: Word operations write Z, C, N, V and S (mask 0x2F) over the 16-bit result. The high byte takes the low byte's carry or borrow, and S = N XOR V.
- R10: Every flag bit whose mask bit is 0 returns the value that `flags_in` had when the operation was accepted.
- R11: A `start` that arrives while `busy` is high is ignored; it produces no result.
- R12: After reset, `res`, `res_hi`, `flags_out`, `flag_we`, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept the operation presented this cycle |
| op | input | 4 | Operation code (R1–R9 encodings) |
| use_imm | input | 1 | Take `imm` instead of `rr` as second byte operand |
| rd | input | DATA_W | First operand; low byte of the pair for word operations |
| rr | input | DATA_W | Second register operand |
| imm | input | DATA_W | Immediate operand |
| rd_hi | input | DATA_W | High byte of the pair for word operations |
| flags_in | input | 6 | Current status vector |
| res | output | DATA_W | Result, or low byte of a word result |
| res_hi | output | DATA_W | High byte of a word result, 0 otherwise |
| flags_out | output | 6 | Updated status vector |
| flag_we | output | 6 | Mask of the flags this operation writes |
| busy | output | 1 | First cycle of a word operation |
| done | output | 1 | Result and flags valid for one cycle |

## Verification
The assertions assume that `op` holds one of the eleven defined codes whenever `start` is high. They also assume that nothing but `start` is sampled while `busy` is high, because they track the last accepted opcode and flag vector to judge each `done` pulse. The stimulus uses only defined codes and separates each issue with an idle cycle. The single deliberate exception is one `start` pulse placed during a busy cycle, which the block must drop.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int NFLAG = 6;
   localparam int FZ = 0;
   localparam int FC = 1;
   localparam int FN = 2;
   localparam int FV = 3;
   localparam int FH = 4;
   localparam int FS = 5;

   localparam logic [NFLAG-1:0] MASK_ARITH = 6'b011111;
   localparam logic [NFLAG-1:0] MASK_LOGIC = 6'b001101;
   localparam logic [NFLAG-1:0] MASK_INV   = 6'b001111;
   localparam logic [NFLAG-1:0] MASK_WORD  = 6'b101111;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0,
      OP_ADC  = 4'h1,
      OP_SUB  = 4'h2,
      OP_SBC  = 4'h3,
      OP_AND  = 4'h4,
      OP_OR   = 4'h5,
      OP_XOR  = 4'h6,
      OP_INV  = 4'h7,
      OP_NEG  = 4'h8,
      OP_WADD = 4'h9,
      OP_WSUB = 4'hA
   } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         hout,
   output logic         vout
);
   localparam int HB = 4;

   logic [W-1:0] b_eff;
   logic         c_eff;
   logic [W:0]   full;
   logic         c_into_msb;
   logic         c_into_hb;

   assign b_eff = sub ? ~b : b;
   assign c_eff = sub ? ~cin : cin;
   assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
   assign sum   = full[W-1:0];

   assign c_into_msb = a[W-1] ^ b_eff[W-1] ^ full[W-1];
   assign c_into_hb  = a[HB] ^ b_eff[HB] ^ full[HB];

   assign cout = sub ? ~full[W] : full[W];
   assign hout = sub ? ~c_into_hb : c_into_hb;
   assign vout = c_into_msb ^ full[W];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   sel,
   output logic [W-1:0] y
);
   always_comb begin
      case (sel)
         2'd1:    y = a | b;
         2'd2:    y = a ^ b;
         default: y = a & b;
      endcase
   end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
   import alu8_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit CHAIN_Z = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        op,
   input  logic              use_imm,
   input  logic [DATA_W-1:0] rd,
   input  logic [DATA_W-1:0] rr,
   input  logic [DATA_W-1:0] imm,
   input  logic [DATA_W-1:0] rd_hi,
   input  logic [NFLAG-1:0]  flags_in,
   output logic [DATA_W-1:0] res,
   output logic [DATA_W-1:0] res_hi,
   output logic [NFLAG-1:0]  flags_out,
   output logic [NFLAG-1:0]  flag_we,
   output logic              busy,
   output logic              done
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 5) begin : g_width_bad
      $error("alu8_flags: DATA_W must be at least 5");
   end

   alu_op_e opc;
   assign opc = alu_op_e'(op);

   logic              accept, is_word;
   logic [DATA_W-1:0] b_sel, ad_a, ad_b, ad_s, lg_y;
   logic              ad_cin, ad_sub, ad_c, ad_h, ad_v, zero_s, sbc_z;

   logic [DATA_W-1:0] lo_q, hi_q;
   logic              carry_q, wsub_q, lo_zero_q;
   logic [NFLAG-1:0]  base_q;

   logic [DATA_W-1:0] n_res;
   logic [NFLAG-1:0]  n_flg, n_we, w_flg;

   assign accept  = start && !busy;
   assign is_word = (opc == OP_WADD) || (opc == OP_WSUB);
   assign b_sel   = use_imm ? imm : rr;
   assign zero_s  = (ad_s == '0);

   // operand steering for the shared adder
   always_comb begin
      ad_a   = rd;
      ad_b   = b_sel;
      ad_cin = 1'b0;
      ad_sub = 1'b0;
      if (busy) begin
         ad_a   = hi_q;
         ad_b   = '0;
         ad_cin = carry_q;
         ad_sub = wsub_q;
      end else begin
         case (opc)
            OP_ADC:  ad_cin = flags_in[FC];
            OP_SUB:  ad_sub = 1'b1;
            OP_SBC:  begin ad_sub = 1'b1; ad_cin = flags_in[FC]; end
            OP_NEG:  begin ad_a = '0; ad_b = rd; ad_sub = 1'b1; end
            OP_WADD: ad_b = imm;
            OP_WSUB: begin ad_b = imm; ad_sub = 1'b1; end
            default: ;
         endcase
      end
   end

   alu8_addsub #(.W(DATA_W)) u_add (
      .a(ad_a), .b(ad_b), .cin(ad_cin), .sub(ad_sub),
      .sum(ad_s), .cout(ad_c), .hout(ad_h), .vout(ad_v)
   );

   alu8_logic #(.W(DATA_W)) u_lgc (
      .a(rd), .b(b_sel), .sel(op[1:0]), .y(lg_y)
   );

   // zero flag of the borrow-chained subtract: variant chosen by parameter
   if (CHAIN_Z) begin : g_zchain
      assign sbc_z = zero_s & flags_in[FZ];
   end else begin : g_zplain
      assign sbc_z = zero_s;
   end

   // byte-operation result and flags
   always_comb begin
      n_res = '0;
      n_we  = '0;
      n_flg = flags_in;
      case (opc)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
            n_res     = ad_s;
            n_we      = MASK_ARITH;
            n_flg[FZ] = (opc == OP_SBC) ? sbc_z : zero_s;
            n_flg[FC] = ad_c;
            n_flg[FN] = ad_s[MSB];
            n_flg[FV] = ad_v;
            n_flg[FH] = ad_h;
         end
         OP_AND, OP_OR, OP_XOR: begin
            n_res     = lg_y;
            n_we      = MASK_LOGIC;
            n_flg[FZ] = (lg_y == '0);
            n_flg[FN] = lg_y[MSB];
            n_flg[FV] = 1'b0;
         end
         OP_INV: begin
            n_res     = ~rd;
            n_we      = MASK_INV;
            n_flg[FZ] = (rd == '1);
            n_flg[FC] = 1'b1;
            n_flg[FN] = ~rd[MSB];
            n_flg[FV] = 1'b0;
         end
         default: ;
      endcase
   end

   // word-operation flags formed in the high-byte cycle
   always_comb begin
      w_flg     = base_q;
      w_flg[FZ] = lo_zero_q & zero_s;
      w_flg[FC] = ad_c;
      w_flg[FN] = ad_s[MSB];
      w_flg[FV] = ad_v;
      w_flg[FS] = ad_s[MSB] ^ ad_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         res       <= '0;
         res_hi    <= '0;
         flags_out <= '0;
         flag_we   <= '0;
         lo_q      <= '0;
         hi_q      <= '0;
         carry_q   <= 1'b0;
         wsub_q    <= 1'b0;
         lo_zero_q <= 1'b0;
         base_q    <= '0;
      end else if (accept && is_word) begin
         busy      <= 1'b1;
         done      <= 1'b0;
         lo_q      <= ad_s;
         hi_q      <= rd_hi;
         carry_q   <= ad_c;
         wsub_q    <= ad_sub;
         lo_zero_q <= zero_s;
         base_q    <= flags_in;
      end else if (accept) begin
         done      <= 1'b1;
         res       <= n_res;
         res_hi    <= '0;
         flags_out <= n_flg;
         flag_we   <= n_we;
      end else if (busy) begin
         busy      <= 1'b0;
         done      <= 1'b1;
         res       <= lo_q;
         res_hi    <= ad_s;
         flags_out <= w_flg;
         flag_we   <= MASK_WORD;
      end else begin
         done      <= 1'b0;
      end
   end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [3:0]        op,
   input logic [5:0]        flags_in,
   input logic [DATA_W-1:0] res_hi,
   input logic [5:0]        flags_out,
   input logic [5:0]        flag_we,
   input logic              busy,
   input logic              done
);
   logic [3:0] op_seen;
   logic [5:0] flg_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_seen  <= '0;
         flg_seen <= '0;
      end else if (start && !busy) begin
         op_seen  <= op;
         flg_seen <= flags_in;
      end
   end

   // R7
   byte_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op < 4'h9) |=> (done && !busy));

   // R8
   word_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (op == 4'h9 || op == 4'hA)) |=> (busy && !done));

   // R8
   busy_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (done && !busy));

   // R4
   logic_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_seen >= 4'h4 && op_seen <= 4'h6) |-> (flag_we == 6'h0D && !flags_out[3]));

   // R5
   inv_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_seen == 4'h7) |-> (flag_we == 6'h0F && flags_out[1] && !flags_out[3]));

   // R9
   word_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (op_seen == 4'h9 || op_seen == 4'hA)) |->
      (flags_out[5] == (flags_out[2] ^ flags_out[3]) && flags_out[2] == res_hi[DATA_W-1]));

   // R10
   unwritten_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (((flags_out ^ flg_seen) & ~flag_we) == 6'h00));
endmodule

bind alu8_flags alu8_flags_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/alu8_flags_test.sv
`timescale 1ns/1ps
module alu8_flags_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] op = '0;
   logic       use_imm = 1'b0;
   logic [7:0] rd = '0, rr = '0, imm = '0, rd_hi = '0;
   logic [5:0] flags_in = '0;
   logic [7:0] res, res_hi;
   logic [5:0] flags_out, flag_we;
   logic       busy, done;

   int checks = 0;
   int fails  = 0;

   typedef struct {
      logic [7:0] r;
      logic [7:0] rh;
      logic [5:0] f;
      logic [5:0] we;
      string      tag;
   } exp_t;
   exp_t sbq[$];

   always #2 clk = ~clk;

   alu8_flags uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .use_imm(use_imm),
      .rd(rd), .rr(rr), .imm(imm), .rd_hi(rd_hi), .flags_in(flags_in),
      .res(res), .res_hi(res_hi), .flags_out(flags_out), .flag_we(flag_we),
      .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   function automatic exp_t model(input logic [3:0] o, input bit ui, input logic [7:0] a8,
                                  input logic [7:0] r8, input logic [7:0] k8,
                                  input logic [7:0] h8, input logic [5:0] fin, input string tag);
      exp_t e;
      int a, b, c, d, w;
      logic [7:0]  r;
      logic [15:0] r16;
      a = int'(a8);
      b = ui ? int'(k8) : int'(r8);
      c = 0;
      e.f = fin; e.rh = '0; e.tag = tag; e.we = '0; e.r = '0;
      case (o)
         4'h0, 4'h1: begin
            c = (o == 4'h1) ? int'(fin[1]) : 0;
            d = a + b + c; r = d[7:0];
            e.we = 6'h1F;
            e.f[0] = (r == 0); e.f[1] = (d > 255); e.f[2] = r[7];
            e.f[3] = (a[7] == b[7]) && (r[7] != a[7]);
            e.f[4] = ((a % 16) + (b % 16) + c) > 15;
            e.r = r;
         end
         4'h2, 4'h3, 4'h8: begin
            if (o == 4'h8) begin b = a; a = 0; end
            c = (o == 4'h3) ? int'(fin[1]) : 0;
            d = a - b - c; r = d[7:0];
            e.we = 6'h1F;
            e.f[0] = (o == 4'h3) ? ((r == 0) && fin[0]) : (r == 0);
            e.f[1] = (d < 0); e.f[2] = r[7];
            e.f[3] = (a[7] != b[7]) && (r[7] != a[7]);
            e.f[4] = ((a % 16) - (b % 16) - c) < 0;
            e.r = r;
         end
         4'h4, 4'h5, 4'h6: begin
            r = (o == 4'h4) ? (a8 & b[7:0]) : (o == 4'h5) ? (a8 | b[7:0]) : (a8 ^ b[7:0]);
            e.we = 6'h0D;
            e.f[0] = (r == 0); e.f[2] = r[7]; e.f[3] = 1'b0;
            e.r = r;
         end
         4'h7: begin
            r = 8'hFF - a8;
            e.we = 6'h0F;
            e.f[0] = (r == 0); e.f[1] = 1'b1; e.f[2] = r[7]; e.f[3] = 1'b0;
            e.r = r;
         end
         default: begin
            w = int'(h8) * 256 + a;
            d = (o == 4'h9) ? w + int'(k8) : w - int'(k8);
            r16 = d[15:0];
            e.we = 6'h2F;
            e.f[0] = (r16 == 0);
            e.f[1] = (o == 4'h9) ? (d > 65535) : (d < 0);
            e.f[2] = r16[15];
            e.f[3] = (o == 4'h9) ? (!w[15] && r16[15]) : (w[15] && !r16[15]);
            e.f[5] = e.f[2] ^ e.f[3];
            e.r = r16[7:0]; e.rh = r16[15:8];
         end
      endcase
      return e;
   endfunction

   task automatic issue(input logic [3:0] o, input bit ui, input logic [7:0] a8,
                        input logic [7:0] r8, input logic [7:0] k8, input logic [7:0] h8,
                        input logic [5:0] fin, input string tag, input bit poke = 1'b0);
      sbq.push_back(model(o, ui, a8, r8, k8, h8, fin, tag));
      @(negedge clk);
      op = o; use_imm = ui; rd = a8; rr = r8; imm = k8; rd_hi = h8; flags_in = fin;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (o >= 4'h9) begin
         // R8: first cycle after acceptance is busy, no result yet
         chk(busy && !done, "R8", "busy/done", {14'd0, busy, done}, 16'h2);
         if (poke) begin
            // R11: start during busy must be dropped
            start = 1'b1; op = 4'h0; rd = 8'h11; rr = 8'h22; flags_in = 6'h00;
         end
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R11", "unexpected result", {8'd0, res}, 16'h0);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            chk(res == e.r && res_hi == e.rh, e.tag, "result", {res_hi, res}, {e.rh, e.r});
            chk(flags_out == e.f, e.tag, "flags", {10'd0, flags_out}, {10'd0, e.f});
            chk(flag_we == e.we, e.tag, "mask", {10'd0, flag_we}, {10'd0, e.we});
            // R7: byte results never appear with busy high
            chk(!busy, "R7", "busy at done", {15'd0, busy}, 16'h0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk({res, res_hi, flags_out, flag_we, busy, done} == '0, "R12", "reset outputs",
          {res, res_hi}, 16'h0);
      chk({busy, done} == 2'b00, "R12", "reset busy/done", {14'd0, busy, done}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 add forms
      issue(4'h0, 0, 8'h0F, 8'h01, 8'h00, 8'h00, 6'h00, "R1");
      issue(4'h0, 0, 8'h7F, 8'h01, 8'h00, 8'h00, 6'h00, "R1");
      issue(4'h0, 1, 8'hFF, 8'h00, 8'h01, 8'h00, 6'h20, "R1");
      issue(4'h1, 0, 8'h3A, 8'h45, 8'h00, 8'h00, 6'h02, "R1");
      issue(4'h1, 0, 8'h80, 8'h7F, 8'h00, 8'h00, 6'h02, "R1");
      // R2 subtract forms
      issue(4'h2, 0, 8'h10, 8'h01, 8'h00, 8'h00, 6'h00, "R2");
      issue(4'h2, 1, 8'h05, 8'h00, 8'h05, 8'h00, 6'h00, "R2");
      issue(4'h2, 0, 8'h80, 8'h01, 8'h00, 8'h00, 6'h00, "R2");
      issue(4'h2, 0, 8'h01, 8'h02, 8'h00, 8'h00, 6'h20, "R2");
      issue(4'h3, 1, 8'h40, 8'h00, 8'h3F, 8'h00, 6'h02, "R2");
      // R3 borrow-chained zero
      issue(4'h3, 0, 8'h05, 8'h04, 8'h00, 8'h00, 6'h03, "R3");
      issue(4'h3, 0, 8'h05, 8'h04, 8'h00, 8'h00, 6'h02, "R3");
      issue(4'h3, 0, 8'h09, 8'h04, 8'h00, 8'h00, 6'h01, "R3");
      // R4 logic, R10 untouched bits with all flags set
      issue(4'h4, 0, 8'hF0, 8'h0F, 8'h00, 8'h00, 6'h3F, "R4");
      issue(4'h5, 1, 8'h80, 8'h00, 8'h01, 8'h00, 6'h08, "R4");
      issue(4'h6, 0, 8'hAA, 8'h55, 8'h00, 8'h00, 6'h32, "R10");
      // R5 one's complement
      issue(4'h7, 0, 8'h00, 8'h00, 8'h00, 8'h00, 6'h38, "R5");
      issue(4'h7, 0, 8'hFF, 8'h00, 8'h00, 8'h00, 6'h00, "R5");
      // R6 two's complement
      issue(4'h8, 0, 8'h00, 8'h00, 8'h00, 8'h00, 6'h00, "R6");
      issue(4'h8, 0, 8'h80, 8'h00, 8'h00, 8'h00, 6'h00, "R6");
      issue(4'h8, 0, 8'h01, 8'h00, 8'h00, 8'h00, 6'h20, "R6");
      // R8/R9 word operations
      issue(4'h9, 0, 8'hFF, 8'h00, 8'h01, 8'h00, 6'h10, "R9");
      issue(4'h9, 0, 8'hFF, 8'h00, 8'h01, 8'h7F, 6'h00, "R9");
      issue(4'h9, 0, 8'hFF, 8'h00, 8'h01, 8'hFF, 6'h10, "R9");
      issue(4'hA, 0, 8'h00, 8'h00, 8'h01, 8'h00, 6'h00, "R9");
      issue(4'hA, 0, 8'h00, 8'h00, 8'h01, 8'h80, 6'h10, "R9");
      issue(4'hA, 0, 8'h34, 8'h00, 8'h20, 8'h12, 6'h3F, "R8");
      // R11 start while busy is dropped
      issue(4'h9, 0, 8'h10, 8'h00, 8'h05, 8'h20, 6'h00, "R11", 1'b1);
      repeat (4) @(negedge clk);
      // R7 byte op after a word op still single cycle
      issue(4'h0, 0, 8'h01, 8'h01, 8'h00, 8'h00, 6'h00, "R7");
      repeat (3) @(negedge clk);
      chk(sbq.size() == 0, "R11", "pending results", 16'(sbq.size()), 16'h0);
      report();
   end
endmodule